// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative holding store placed beside a direct-mapped first-level cache. When that cache throws a line out, the line is handed to this store rather than being lost. When the first-level cache misses, it probes the store. All entries are compared with the probe address in the same cycle. A hit hands the line straight back, so the slow next-level fetch is avoided. A miss passes the request on to the next memory level.

A line recovered by a hit leaves the store, because it now lives in the first-level cache again. If the first-level cache is evicting a line in that same cycle, the hit entry is overwritten with the evicted line, so the two lines trade places. When the store is full, a new line displaces the entry that was allocated longest ago. A displaced entry that carries modified data is written back to the next level. The entry count can be set from 4 to 16, and elaboration rejects any count outside that range.

Top module: `victim_buffer`

## Requirements
- R1: After reset the store holds no lines, every output is 0, and the first lookup misses.
- R2: One cycle after `lk_valid`, `rsp_valid` is 1. If a valid entry holds the probed block, `rsp_hit` is 1, `rsp_data` and `rsp_dirty` carry that entry's contents, and `fwd_valid` stays 0.
- R3: On a lookup miss, one cycle later `rsp_hit`, `rsp_dirty` and `rsp_data` are 0, `fwd_valid` is 1, and `fwd_addr` is the probe address with its low `OFFS_W` bits cleared.
- R4: Entries are matched on address bits `[ADDR_W-1:OFFS_W]` only. Addresses that differ only in the low `OFFS_W` bits name the same line.
- R5: A lookup hit with no insert in the same cycle frees the hit entry, so a repeat lookup of that block misses.
- R6: A lookup hit together with an insert overwrites the hit entry with the inserted line. Afterwards the old block misses and the inserted block hits, and the number of held lines does not change.
- R7: An insert of a block that is not held fills a free entry when one exists, and no write-back is raised.
- R8: An insert of a new block into a full store replaces the entry allocated earliest. A swap counts as a fresh allocation; an in-place update does not.
- R9: If the replaced entry is dirty, then one cycle later `wb_valid` is 1, `wb_addr` is that entry's block address with the low `OFFS_W` bits 0, and `wb_data` is its data. A clean replaced entry raises no write-back.
- R10: An insert whose block already sits in a valid entry, with no lookup hit in that cycle, updates that entry in place. The data is replaced, the dirty flag becomes old OR new, and the entry's age is unchanged.
- R11: No block address is ever held in two valid entries at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | A line evicted from the first-level cache is offered |
| ins_addr | input | ADDR_W | Address of the offered line |
| ins_data | input | LINE_W | Contents of the offered line |
| ins_dirty | input | 1 | Offered line differs from the next level |
| lk_valid | input | 1 | Probe from a first-level miss |
| lk_addr | input | ADDR_W | Probe address |
| rsp_valid | output | 1 | Probe result is present (one cycle pulse) |
| rsp_hit | output | 1 | Probe found its line |
| rsp_data | output | LINE_W | Line returned on a hit, 0 otherwise |
| rsp_dirty | output | 1 | Modified flag of the returned line |
| fwd_valid | output | 1 | Read request to the next level (one cycle pulse) |
| fwd_addr | output | ADDR_W | Block-aligned address of that read |
| wb_valid | output | 1 | Write request to the next level (one cycle pulse) |
| wb_addr | output | ADDR_W | Block-aligned address being written back |
| wb_data | output | LINE_W | Line being written back |

## Verification
The swap path assumes that an evicted line offered while a probe hits is not itself held in the store. The first-level cache and this store keep disjoint contents, so this holds in use. Under that rule, the unique-address and constant-count assertions can trust the insert path. The random stimulus draws blocks from a pool of twenty against eight entries, which makes hits, fills and replacements frequent. Whenever a drawn insert would coincide with a lookup hit on a held block, the stimulus redraws the insert address until it names a block the reference model does not hold.

// File: rtl/vb_pkg.sv
package vb_pkg;

   // action taken on the entry array in one cycle
   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_FREE,
      ACT_SWAP,
      ACT_UPDATE,
      ACT_ALLOC
   } vb_act_e;

   localparam int unsigned VB_MIN_ENTRIES = 4;
   localparam int unsigned VB_MAX_ENTRIES = 16;

endpackage

// File: rtl/vb_cam.sv
// Parallel comparator: one equality test per entry, all in the same cycle.
module vb_cam #(
   parameter int unsigned N     = 8,
   parameter int unsigned KEY_W = 22
) (
   input  logic [N-1:0][KEY_W-1:0] keys,
   input  logic [N-1:0]            live,
   input  logic [KEY_W-1:0]        probe,
   output logic [N-1:0]            match
);

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = live[g] && (keys[g] == probe);
   end

endmodule

// File: rtl/vb_lsb_pick.sv
// Returns the index of the lowest set bit of a vector.
module vb_lsb_pick #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/vb_order.sv
// Allocation order tracker. Each live entry carries a rank: 0 is the newest,
// and the live ranks always form 0..count-1, so a full array has exactly one
// entry of rank N-1, which is the oldest.
module vb_order #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     live,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx,
   input  logic             mark_was_live,
   input  logic             drop_en,
   input  logic [IDX_W-1:0] drop_idx,
   output logic [IDX_W-1:0] oldest_idx
);

   logic [N-1:0][IDX_W-1:0] rank_q;
   logic [N-1:0]            top_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rank_q <= '0;
      end else begin
         for (int j = 0; j < N; j++) begin
            if (mark_en) begin
               if (IDX_W'(j) == mark_idx)
                  rank_q[j] <= '0;
               else if (live[j] && (!mark_was_live || rank_q[j] < rank_q[mark_idx]))
                  rank_q[j] <= rank_q[j] + 1'b1;
            end else if (drop_en) begin
               if (live[j] && IDX_W'(j) != drop_idx && rank_q[j] > rank_q[drop_idx])
                  rank_q[j] <= rank_q[j] - 1'b1;
            end
         end
      end
   end

   always_comb begin
      oldest_idx = '0;
      for (int j = 0; j < N; j++) begin
         top_vec[j] = live[j] && (rank_q[j] == IDX_W'(N - 1));
      end
      for (int j = N - 1; j >= 0; j--) begin
         if (top_vec[j]) oldest_idx = IDX_W'(j);
      end
   end

   // a full array must name exactly one oldest entry
   assert_single_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (&live) |-> ($countones(top_vec) == 1))
      else $error("full store without a unique oldest entry");

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned OFFS_W  = 2,
   parameter int unsigned LINE_W  = 32,
   parameter int unsigned ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [LINE_W-1:0] ins_data,
   input  logic              ins_dirty,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [LINE_W-1:0] rsp_data,
   output logic              rsp_dirty,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [LINE_W-1:0] wb_data
);
   import vb_pkg::*;

   localparam int unsigned TAG_W = ADDR_W - OFFS_W;
   localparam int unsigned IDX_W = $clog2(ENTRIES);

   if (ENTRIES < VB_MIN_ENTRIES || ENTRIES > VB_MAX_ENTRIES) begin : g_bad_entries
      $error("ENTRIES must lie between 4 and 16");
   end
   if (OFFS_W < 1 || OFFS_W >= ADDR_W) begin : g_bad_offset
      $error("OFFS_W must be at least 1 and below ADDR_W");
   end

   // entry array
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0]             dirty_q;
   logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
   logic [ENTRIES-1:0][LINE_W-1:0] data_q;

   logic [TAG_W-1:0]   lk_tag, ins_tag;
   logic [ENTRIES-1:0] lk_vec, ins_vec;
   logic [IDX_W-1:0]   hit_idx, ins_idx, free_idx, oldest_idx, tgt_idx;
   logic               lk_any, ins_any, free_any;
   logic               lk_hit, ins_match, full;
   vb_act_e            act;
   logic               unused_lowbits;

   assign lk_tag  = lk_addr[ADDR_W-1:OFFS_W];
   assign ins_tag = ins_addr[ADDR_W-1:OFFS_W];
   assign unused_lowbits = ^{lk_addr[OFFS_W-1:0], ins_addr[OFFS_W-1:0], free_any};

   vb_cam #(.N(ENTRIES), .KEY_W(TAG_W)) u_cam_lk (
      .keys(tag_q), .live(valid_q), .probe(lk_tag), .match(lk_vec));

   vb_cam #(.N(ENTRIES), .KEY_W(TAG_W)) u_cam_ins (
      .keys(tag_q), .live(valid_q), .probe(ins_tag), .match(ins_vec));

   vb_lsb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_hit (
      .vec(lk_vec), .idx(hit_idx), .any(lk_any));

   vb_lsb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_ins (
      .vec(ins_vec), .idx(ins_idx), .any(ins_any));

   vb_lsb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_free (
      .vec(~valid_q), .idx(free_idx), .any(free_any));

   assign lk_hit    = lk_valid && lk_any;
   assign ins_match = ins_valid && ins_any;
   assign full      = &valid_q;

   always_comb begin
      if (lk_hit && ins_valid)  act = ACT_SWAP;
      else if (lk_hit)          act = ACT_FREE;
      else if (ins_match)       act = ACT_UPDATE;
      else if (ins_valid)       act = ACT_ALLOC;
      else                      act = ACT_NONE;
      if (act == ACT_SWAP)      tgt_idx = hit_idx;
      else if (full)            tgt_idx = oldest_idx;
      else                      tgt_idx = free_idx;
   end

   vb_order #(.N(ENTRIES), .IDX_W(IDX_W)) u_order (
      .clk           (clk),
      .rst_n         (rst_n),
      .live          (valid_q),
      .mark_en       (act == ACT_SWAP || act == ACT_ALLOC),
      .mark_idx      (tgt_idx),
      .mark_was_live (act == ACT_SWAP || full),
      .drop_en       (act == ACT_FREE),
      .drop_idx      (hit_idx),
      .oldest_idx    (oldest_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         tag_q   <= '0;
         data_q  <= '0;
      end else begin
         unique case (act)
            ACT_FREE: valid_q[hit_idx] <= 1'b0;
            ACT_SWAP, ACT_ALLOC: begin
               valid_q[tgt_idx] <= 1'b1;
               tag_q[tgt_idx]   <= ins_tag;
               data_q[tgt_idx]  <= ins_data;
               dirty_q[tgt_idx] <= ins_dirty;
            end
            ACT_UPDATE: begin
               data_q[ins_idx]  <= ins_data;
               dirty_q[ins_idx] <= dirty_q[ins_idx] | ins_dirty;
            end
            default: ;
         endcase
      end
   end

   // registered response, forward and write-back channels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
         rsp_dirty <= 1'b0;
         fwd_valid <= 1'b0;
         fwd_addr  <= '0;
         wb_valid  <= 1'b0;
         wb_addr   <= '0;
         wb_data   <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_hit;
         rsp_data  <= lk_hit ? data_q[hit_idx] : '0;
         rsp_dirty <= lk_hit && dirty_q[hit_idx];
         fwd_valid <= lk_valid && !lk_hit;
         fwd_addr  <= {lk_tag, {OFFS_W{1'b0}}};
         wb_valid  <= (act == ACT_ALLOC) && full && dirty_q[oldest_idx];
         wb_addr   <= {tag_q[oldest_idx], {OFFS_W{1'b0}}};
         wb_data   <= data_q[oldest_idx];
      end
   end

   assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid)
      else $error("lookup without response");

   assert_hit_no_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_valid && !fwd_valid))
      else $error("hit also forwarded");

   assert_miss_forwards_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_hit) |=>
         (fwd_valid && !rsp_hit && fwd_addr[ADDR_W-1:OFFS_W] == $past(lk_addr[ADDR_W-1:OFFS_W])))
      else $error("miss not forwarded correctly");

   assert_free_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !ins_valid) |=> ($countones(valid_q) == $past($countones(valid_q)) - 1))
      else $error("hit entry not released");

   assert_swap_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && ins_valid) |=> ($countones(valid_q) == $past($countones(valid_q))))
      else $error("swap changed the number of held lines");

   assert_wb_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ($past(full) && $past(ins_valid)))
      else $error("write-back without a full-store insert");

   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
               assert_unique_tags_R11: assert (!(valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]))
                  else $error("block held twice");
            end
         end
      end
   end

endmodule

// File: tb/victim_buffer_test.sv
module victim_buffer_test;

   localparam int AW = 24;
   localparam int OW = 2;
   localparam int LW = 32;
   localparam int NE = 8;
   localparam int TW = AW - OW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          ins_valid, ins_dirty, lk_valid;
   logic [AW-1:0] ins_addr, lk_addr;
   logic [LW-1:0] ins_data;
   logic          rsp_valid, rsp_hit, rsp_dirty, fwd_valid, wb_valid;
   logic [LW-1:0] rsp_data, wb_data;
   logic [AW-1:0] fwd_addr, wb_addr;

   victim_buffer #(.ADDR_W(AW), .OFFS_W(OW), .LINE_W(LW), .ENTRIES(NE)) uut (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data), .ins_dirty(ins_dirty),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model: slots plus allocation stamps
   bit          mv [NE];
   logic [TW-1:0] mt [NE];
   logic [LW-1:0] md [NE];
   bit          mdr [NE];
   int          ms [NE];
   int          stamp = 0;

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int m_find(input logic [TW-1:0] t);
      for (int i = 0; i < NE; i++) if (mv[i] && mt[i] == t) return i;
      return -1;
   endfunction

   function automatic logic [AW-1:0] blk(input int b, input int off);
      return AW'(b * (1 << OW) + off);
   endfunction

   task automatic step(input bit lv, input logic [AW-1:0] la,
                       input bit iv, input logic [AW-1:0] ia,
                       input logic [LW-1:0] id, input bit idy);
      int h, m, slot;
      bit e_hit, e_dirty, e_fwd, e_wb;
      logic [LW-1:0] e_data, e_wbd;
      logic [AW-1:0] e_fwa, e_wba;
      h = lv ? m_find(la[AW-1:OW]) : -1;
      m = iv ? m_find(ia[AW-1:OW]) : -1;
      e_hit   = (h >= 0);
      e_data  = e_hit ? md[h] : '0;
      e_dirty = e_hit ? mdr[h] : 1'b0;
      e_fwd   = lv && !e_hit;
      e_fwa   = {la[AW-1:OW], {OW{1'b0}}};
      e_wb    = 1'b0;
      e_wba   = '0;
      e_wbd   = '0;
      if (e_hit && iv) begin            // R6 swap
         mt[h] = ia[AW-1:OW]; md[h] = id; mdr[h] = idy; stamp++; ms[h] = stamp;
      end else if (e_hit) begin         // R5 release
         mv[h] = 1'b0;
      end else if (iv) begin
         if (m >= 0) begin              // R10 in-place update
            md[m] = id; mdr[m] = mdr[m] | idy;
         end else begin
            slot = -1;
            for (int i = 0; i < NE; i++) if (!mv[i] && slot < 0) slot = i;  // R7
            if (slot < 0) begin         // R8 earliest allocation goes
               slot = 0;
               for (int i = 1; i < NE; i++) if (ms[i] < ms[slot]) slot = i;
               if (mdr[slot]) begin     // R9
                  e_wb = 1'b1; e_wba = {mt[slot], {OW{1'b0}}}; e_wbd = md[slot];
               end
            end
            mv[slot] = 1'b1; mt[slot] = ia[AW-1:OW]; md[slot] = id; mdr[slot] = idy;
            stamp++; ms[slot] = stamp;
         end
      end
      lk_valid = lv; lk_addr = la;
      ins_valid = iv; ins_addr = ia; ins_data = id; ins_dirty = idy;
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0; ins_valid = 1'b0;
      check(e_hit ? "R2" : "R3", "response",
            {rsp_valid, rsp_hit, rsp_dirty, rsp_data}, {lv, e_hit, e_dirty, e_data});
      check("R3", "forward", {fwd_valid, fwd_valid ? fwd_addr : {AW{1'b0}}},
            {e_fwd, e_fwd ? e_fwa : {AW{1'b0}}});
      check("R9", "write-back",
            {wb_valid, wb_valid ? wb_addr : {AW{1'b0}}, wb_valid ? wb_data : {LW{1'b0}}},
            {e_wb, e_wba, e_wbd});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NE; i++) begin
         mv[i] = 1'b0; mt[i] = '0; md[i] = '0; mdr[i] = 1'b0; ms[i] = 0;
      end
      lk_valid = 1'b0; lk_addr = '0;
      ins_valid = 1'b0; ins_addr = '0; ins_data = '0; ins_dirty = 1'b0;
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      // R1: outputs idle in reset and just after it
      check("R1", "outputs in reset",
            {rsp_valid, rsp_hit, rsp_dirty, fwd_valid, wb_valid, rsp_data},
            {5'b0, {LW{1'b0}}});
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs after reset",
            {rsp_valid, rsp_hit, rsp_dirty, fwd_valid, wb_valid, rsp_data},
            {5'b0, {LW{1'b0}}});
      // R1: empty store misses; R3 forward address aligned
      step(1, blk(32'h100, 3), 0, '0, '0, 0);
      // R7 fill, R4 offset ignored, R2 hit, R5 second probe misses
      step(0, '0, 1, blk(32'h10, 1), 32'hA0A0_0001, 0);
      step(1, blk(32'h10, 3), 0, '0, '0, 0);
      step(1, blk(32'h10, 0), 0, '0, '0, 0);
      // R10 in-place update merges dirty
      step(0, '0, 1, blk(32'h11, 0), 32'h1111_0001, 0);
      step(0, '0, 1, blk(32'h11, 2), 32'h1111_0002, 1);
      step(0, '0, 1, blk(32'h11, 1), 32'h1111_0003, 0);
      step(1, blk(32'h11, 0), 0, '0, '0, 0);
      // R8 and R9 fill then overflow
      for (int i = 0; i < NE; i++)
         step(0, '0, 1, blk(32'h20 + i, 0), 32'hD000_0000 + i, (i % 2) == 0);
      step(0, '0, 1, blk(32'h28, 0), 32'hD000_0028, 0);   // replaces dirty 0x20
      step(0, '0, 1, blk(32'h29, 0), 32'hD000_0029, 0);   // replaces clean 0x21
      step(1, blk(32'h21, 0), 0, '0, '0, 0);              // gone
      step(1, blk(32'h22, 0), 0, '0, '0, 0);              // hit, released
      step(0, '0, 1, blk(32'h2A, 0), 32'hD000_002A, 0);   // free slot
      step(0, '0, 1, blk(32'h2B, 0), 32'hD000_002B, 1);   // replaces 0x23
      step(0, '0, 1, blk(32'h24, 1), 32'hD100_0024, 0);   // R10 update keeps age
      step(0, '0, 1, blk(32'h2C, 0), 32'hD000_002C, 0);   // replaces 0x24
      // R6 swap
      step(1, blk(32'h25, 0), 1, blk(32'h30, 0), 32'h3030_3030, 1);
      step(1, blk(32'h25, 0), 0, '0, '0, 0);
      step(1, blk(32'h30, 2), 0, '0, '0, 0);
      // random traffic
      for (int n = 0; n < 3000; n++) begin
         bit lv, iv, idy;
         logic [AW-1:0] la, ia;
         logic [LW-1:0] id;
         lv  = ($urandom % 2) == 0;
         iv  = ($urandom % 3) != 0;
         idy = ($urandom % 2) == 0;
         id  = $urandom;
         la  = blk(32'h40 + ($urandom % 20), $urandom % 4);
         ia  = blk(32'h40 + ($urandom % 20), $urandom % 4);
         if (lv && iv && m_find(la[AW-1:OW]) >= 0) begin
            while (m_find(ia[AW-1:OW]) >= 0)
               ia = blk(32'h40 + ($urandom % 20), $urandom % 4);
         end
         step(lv, la, iv, ia, id, idy);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule